// File: doc/BRIEF.md
# Two-Read One-Write Register File with Replicated Banks

This block is the general-purpose register store of a small 32-bit processor core. It holds 32 words of 32 bits, 1024 bits in all. It serves two operand reads and one result write in every clock cycle. The design does not use a single array with three ports. It keeps two identical copies of the storage. Each copy is a plain simple-dual-port synchronous RAM with one read port and one write port.

Every write goes to both copies at the same time, so the copies always hold the same data. Read port A draws only on copy 0, and read port B draws only on copy 1. Reads are synchronous: the address is captured on a rising clock edge, and the data is valid after that edge. A read and a write to the same entry in one cycle return the value stored before the write. Entry 0 is hard-wired to zero when the `ZERO_REG` option is set, which is the default.

Top module: `dualread_regfile`

## Requirements
- R1: After a rising edge at which `rst_n` is high, `rd_a_data` holds the entry addressed by `rd_a_addr` at that edge.
- R2: `rd_b_data` behaves in the same way for `rd_b_addr`, independently of port A, including when the two addresses differ.
- R3: With `wr_en` high at a rising edge, entry `wr_addr` takes `wr_data`, and reads on either port captured at later edges return it.
- R4: With `wr_en` low at an edge, no entry changes, whatever `wr_addr` and `wr_data` carry.
- R5: When a read address equals `wr_addr` during a write, that port returns the value held before the write. This holds for both ports alike, and the new value appears on the next read.
- R6: Address 0 always reads as zero on both ports, and writes to address 0 have no effect.
- R7: While `rst_n` is low, both read data outputs are zero.
- R8: When both ports read the same address, they return identical data.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous active-low reset of the read data registers |
| wr_en | input | 1 | Write strobe, shared by both banks |
| wr_addr | input | ADDR_W (5) | Entry to write |
| wr_data | input | DATA_W (32) | Value to write |
| rd_a_addr | input | ADDR_W (5) | Read port A address, served by bank 0 |
| rd_a_data | output | DATA_W (32) | Read port A data, one cycle after its address |
| rd_b_addr | input | ADDR_W (5) | Read port B address, served by bank 1 |
| rd_b_data | output | DATA_W (32) | Read port B data, one cycle after its address |

## Verification
The properties assume the following about the inputs:
- All inputs are known at every rising edge once reset is released.
- Reset is held for at least one edge.
- Each entry is written before either port reads it, since the RAM copies themselves are never cleared.

The stimulus respects these assumptions in three ways. It changes inputs only on falling edges. It holds reset low for several cycles at the start. It fills every entry in order before it issues random or table-driven reads. The read-equality property then compares the two banks only through the ports, and only once both banks have been loaded identically.

// File: rtl/rf2_pkg.sv
`timescale 1ns/1ps
package rf2_pkg;
   localparam int RF_DATA_W_DEF = 32;
   localparam int RF_ADDR_W_DEF = 5;
   localparam int RF_NUM_BANKS  = 2;

   typedef enum logic [0:0] {
      BANK_PORT_A = 1'b0,
      BANK_PORT_B = 1'b1
   } rf_bank_e;

   function automatic logic rf_is_zero_addr(input logic [31:0] addr);
      return addr == 32'd0;
   endfunction
endpackage

// File: rtl/rf2_sdp_bank.sv
`timescale 1ns/1ps
module rf2_sdp_bank #(
   parameter int ADDR_W = 5,
   parameter int DATA_W = 32
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              we,
   input  logic [ADDR_W-1:0] waddr,
   input  logic [DATA_W-1:0] wdata,
   input  logic [ADDR_W-1:0] raddr,
   output logic [DATA_W-1:0] rdata
);
   localparam int DEPTH = 1 << ADDR_W;

   logic [DATA_W-1:0] mem_q [DEPTH];

   // storage array: no reset, as a RAM macro would have
   always_ff @(posedge clk) begin
      if (we) mem_q[waddr] <= wdata;
   end

   // registered read; sees the array before this edge's write
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) rdata <= '0;
      else        rdata <= mem_q[raddr];
   end
endmodule

// File: rtl/rf2_read_mask.sv
`timescale 1ns/1ps
module rf2_read_mask #(
   parameter int  ADDR_W   = 5,
   parameter int  DATA_W   = 32,
   parameter bit  ZERO_REG = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [ADDR_W-1:0] raddr,
   input  logic [DATA_W-1:0] bank_rdata,
   output logic [DATA_W-1:0] rdata
);
   logic zero_q;

   // tracks, in step with the bank's read register, whether entry 0 was read
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) zero_q <= 1'b1;
      else        zero_q <= ZERO_REG &&
                            rf2_pkg::rf_is_zero_addr(32'(raddr));
   end

   assign rdata = zero_q ? '0 : bank_rdata;
endmodule

// File: rtl/dualread_regfile.sv
`timescale 1ns/1ps
module dualread_regfile #(
   parameter int ADDR_W   = rf2_pkg::RF_ADDR_W_DEF,
   parameter int DATA_W   = rf2_pkg::RF_DATA_W_DEF,
   parameter bit ZERO_REG = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [ADDR_W-1:0] wr_addr,
   input  logic [DATA_W-1:0] wr_data,
   input  logic [ADDR_W-1:0] rd_a_addr,
   output logic [DATA_W-1:0] rd_a_data,
   input  logic [ADDR_W-1:0] rd_b_addr,
   output logic [DATA_W-1:0] rd_b_data
);
   localparam int NBANK = rf2_pkg::RF_NUM_BANKS;

   if (ADDR_W < 1 || ADDR_W > 10) begin : g_bad_addr
      $error("dualread_regfile: ADDR_W out of range");
   end
   if (DATA_W < 1) begin : g_bad_data
      $error("dualread_regfile: DATA_W must be positive");
   end

   logic              bank_we;
   logic [ADDR_W-1:0] rd_addr_arr [NBANK];
   logic [DATA_W-1:0] bank_q_arr  [NBANK];
   logic [DATA_W-1:0] rd_data_arr [NBANK];

   // write qualification variant: entry 0 protected or ordinary
   if (ZERO_REG) begin : g_wr_guard
      assign bank_we = wr_en && (wr_addr != '0);
   end else begin : g_wr_plain
      assign bank_we = wr_en;
   end

   assign rd_addr_arr[rf2_pkg::BANK_PORT_A] = rd_a_addr;
   assign rd_addr_arr[rf2_pkg::BANK_PORT_B] = rd_b_addr;

   // replicated banks: shared write side, private read side
   for (genvar b = 0; b < NBANK; b++) begin : g_bank
      rf2_sdp_bank #(
         .ADDR_W (ADDR_W),
         .DATA_W (DATA_W)
      ) bank_i (
         .clk   (clk),
         .rst_n (rst_n),
         .we    (bank_we),
         .waddr (wr_addr),
         .wdata (wr_data),
         .raddr (rd_addr_arr[b]),
         .rdata (bank_q_arr[b])
      );

      rf2_read_mask #(
         .ADDR_W   (ADDR_W),
         .DATA_W   (DATA_W),
         .ZERO_REG (ZERO_REG)
      ) mask_i (
         .clk        (clk),
         .rst_n      (rst_n),
         .raddr      (rd_addr_arr[b]),
         .bank_rdata (bank_q_arr[b]),
         .rdata      (rd_data_arr[b])
      );
   end

   assign rd_a_data = rd_data_arr[rf2_pkg::BANK_PORT_A];
   assign rd_b_data = rd_data_arr[rf2_pkg::BANK_PORT_B];
endmodule

// File: rtl/rf2_sva.sv
`timescale 1ns/1ps
module rf2_sva #(
   parameter int ADDR_W   = 5,
   parameter int DATA_W   = 32,
   parameter bit ZERO_REG = 1'b1
) (
   input logic              clk,
   input logic              rst_n,
   input logic              wr_en,
   input logic [ADDR_W-1:0] wr_addr,
   input logic [ADDR_W-1:0] rd_a_addr,
   input logic [DATA_W-1:0] rd_a_data,
   input logic [ADDR_W-1:0] rd_b_addr,
   input logic [DATA_W-1:0] rd_b_data
);
   logic [1:0] run_cnt;
   logic       warm;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)            run_cnt <= '0;
      else if (run_cnt != 2'd3) run_cnt <= run_cnt + 2'd1;
   end
   assign warm = (run_cnt == 2'd3);

   // R7
   reset_zero_chk: assert property (@(posedge clk)
      !rst_n |=> (rd_a_data == '0 && rd_b_data == '0));

   // R6
   zero_read_a_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (ZERO_REG && rd_a_addr == '0) |=> rd_a_data == '0);

   // R6
   zero_read_b_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (ZERO_REG && rd_b_addr == '0) |=> rd_b_data == '0);

   // R8
   bank_match_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (warm && rd_a_addr == rd_b_addr) |=> rd_a_data == rd_b_data);

   // R4
   hold_a_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (warm && rd_a_addr == $past(rd_a_addr) &&
       !($past(wr_en) && $past(wr_addr) == rd_a_addr)) |=> $stable(rd_a_data));

   // R4
   hold_b_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (warm && rd_b_addr == $past(rd_b_addr) &&
       !($past(wr_en) && $past(wr_addr) == rd_b_addr)) |=> $stable(rd_b_data));
endmodule

bind dualread_regfile rf2_sva #(
   .ADDR_W   (ADDR_W),
   .DATA_W   (DATA_W),
   .ZERO_REG (ZERO_REG)
) sva_i (
   .clk       (clk),
   .rst_n     (rst_n),
   .wr_en     (wr_en),
   .wr_addr   (wr_addr),
   .rd_a_addr (rd_a_addr),
   .rd_a_data (rd_a_data),
   .rd_b_addr (rd_b_addr),
   .rd_b_data (rd_b_data)
);

// File: tb/dualread_regfile_tb_top.sv
`timescale 1ns/1ps
module dualread_regfile_tb_top;
   localparam int AW = 5;
   localparam int DW = 32;
   localparam int NV = 12;
   localparam int VW = 1 + AW + DW + AW + AW;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          wr_en = 1'b0;
   logic [AW-1:0] wr_addr = '0;
   logic [DW-1:0] wr_data = '0;
   logic [AW-1:0] rd_a_addr = '0;
   logic [AW-1:0] rd_b_addr = '0;
   logic [DW-1:0] rd_a_data, rd_b_data;

   int checks = 0;
   int errors = 0;
   bit done = 1'b0;
   logic [DW-1:0] ref_mem [1<<AW];

   // {we, waddr, wdata, raddr_a, raddr_b}
   localparam logic [VW-1:0] VEC [NV] = '{
      {1'b1, 5'd3,  32'hC0DE_0003, 5'd3,  5'd4 },
      {1'b0, 5'd3,  32'hBAD0_0000, 5'd3,  5'd3 },
      {1'b1, 5'd31, 32'h8000_0001, 5'd31, 5'd1 },
      {1'b1, 5'd0,  32'hFFFF_FFFF, 5'd0,  5'd0 },
      {1'b1, 5'd12, 32'h0000_1212, 5'd11, 5'd12},
      {1'b0, 5'd12, 32'h7777_7777, 5'd12, 5'd12},
      {1'b1, 5'd1,  32'h0101_0101, 5'd1,  5'd31},
      {1'b1, 5'd2,  32'h2222_0000, 5'd1,  5'd2 },
      {1'b0, 5'd0,  32'h0,         5'd2,  5'd0 },
      {1'b1, 5'd16, 32'hAAAA_5555, 5'd15, 5'd17},
      {1'b1, 5'd16, 32'h5555_AAAA, 5'd16, 5'd16},
      {1'b0, 5'd16, 32'h0,         5'd16, 5'd16}
   };

   dualread_regfile dut_i (
      .clk       (clk),
      .rst_n     (rst_n),
      .wr_en     (wr_en),
      .wr_addr   (wr_addr),
      .wr_data   (wr_data),
      .rd_a_addr (rd_a_addr),
      .rd_a_data (rd_a_data),
      .rd_b_addr (rd_b_addr),
      .rd_b_data (rd_b_data)
   );

   always #5 clk = ~clk;

   task automatic check(input string tag, input logic [DW-1:0] act, input logic [DW-1:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual %h expected %h", tag, act, exp);
      end
   endtask

   // one cycle: drive at falling edge, model, sample just after the rising edge
   task automatic cyc(input logic we, input logic [AW-1:0] wa, input logic [DW-1:0] wd,
                      input logic [AW-1:0] ra, input logic [AW-1:0] rb,
                      input string ta, input string tb);
      logic [DW-1:0] ea, eb;
      @(negedge clk);
      wr_en = we; wr_addr = wa; wr_data = wd; rd_a_addr = ra; rd_b_addr = rb;
      ea = ref_mem[ra];
      eb = ref_mem[rb];
      if (we && wa != '0) ref_mem[wa] = wd;
      @(posedge clk); #1;
      check(ta, rd_a_data, ea);
      check(tb, rd_b_data, eb);
   endtask

   task automatic finish_run();
      if (!done) begin
         done = 1'b1;
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      finish_run();
   end

   initial begin
      for (int i = 0; i < (1<<AW); i++) ref_mem[i] = '0;

      // R7: outputs cleared while reset is held
      rd_a_addr = 5'd9; rd_b_addr = 5'd17;
      repeat (3) @(posedge clk);
      #1;
      check("R7 port A in reset", rd_a_data, '0);
      check("R7 port B in reset", rd_b_data, '0);
      @(negedge clk) rst_n = 1'b1;

      // fill every entry; read back the previous one on A, zero on B
      for (int i = 1; i < (1<<AW); i++)
         cyc(1'b1, AW'(i), (32'h0101_0101 * i) ^ 32'hA500_0000, AW'(i-1), '0, "R1", "R6");

      // R8: both banks agree on every entry
      for (int i = 0; i < (1<<AW); i++) begin
         cyc(1'b0, '0, '0, AW'(i), AW'(i), "R1", "R2");
         check("R8 ports agree", rd_a_data, rd_b_data);
      end

      // table walk
      for (int v = 0; v < NV; v++)
         cyc(VEC[v][VW-1], VEC[v][VW-2 -: AW], VEC[v][VW-2-AW -: DW],
             VEC[v][2*AW-1 -: AW], VEC[v][AW-1:0], "R1", "R2");

      // R3: write then read on both ports
      cyc(1'b1, 5'd7, 32'h1357_9BDF, 5'd8, 5'd9, "R1", "R2");
      cyc(1'b0, '0, '0, 5'd7, 5'd7, "R3 port A", "R3 port B");
      // R4: disabled write leaves the entry intact
      cyc(1'b0, 5'd7, 32'hDEAD_BEEF, 5'd1, 5'd2, "R1", "R2");
      cyc(1'b0, '0, '0, 5'd7, 5'd7, "R4 port A", "R4 port B");
      check("R4 value kept", rd_a_data, 32'h1357_9BDF);
      // R5: same-cycle collision returns the old value, then the new one
      cyc(1'b1, 5'd9, 32'h0F0F_F0F0, 5'd9, 5'd9, "R5 port A", "R5 port B");
      check("R5 old value A", rd_a_data, (32'h0101_0101 * 9) ^ 32'hA500_0000);
      cyc(1'b0, '0, '0, 5'd9, 5'd9, "R5 port A new", "R5 port B new");
      check("R5 new value B", rd_b_data, 32'h0F0F_F0F0);
      // R6: write to entry 0 ignored
      cyc(1'b1, 5'd0, 32'h1234_5678, 5'd0, 5'd0, "R6 port A", "R6 port B");
      cyc(1'b0, '0, '0, 5'd0, 5'd0, "R6 port A after", "R6 port B after");
      check("R6 zero after write", rd_b_data, '0);

      // random traffic with independent addresses
      for (int n = 0; n < 400; n++)
         cyc(1'($urandom), AW'($urandom), $urandom, AW'($urandom), AW'($urandom), "R1", "R2");

      for (int i = 0; i < (1<<AW); i++) begin
         cyc(1'b0, '0, '0, AW'(i), AW'(i), "R1", "R2");
         check("R8 ports agree after random", rd_a_data, rd_b_data);
      end

      finish_run();
   end
endmodule